// File: doc/BRIEF.md
# Fetch and Indirect Micro-Operation Sequencer

This block is a hardwired control unit with a small register datapath. The datapath holds four registers: the address register, the buffer register, the program counter and the instruction register. The controller runs a fixed schedule of register transfers, one transfer group per clock. First comes a three-step instruction fetch. If the fetched word asks for it, a three-step indirect addressing cycle follows. The sequence always ends with a single placeholder execute step, which returns to fetch.

Memory is reached through a plain read port. The address is always the address register, and a read strobe goes high in the step where the buffer register captures the data. The memory is synchronous with the address already registered, so data presented in the strobe step is captured at the end of that same clock, with no wait states.

An instruction word is 16 bits. The opcode is in bits 15:12, the indirect flag is bit 11, and bits 10:0 are the address field. The current cycle and step, the instruction register and the program counter are brought out so that every transfer can be checked against the schedule.

Top module: `uop_sequencer`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the instruction register and all internal registers to zero. It also places the controller in the fetch cycle, step 1, with the read strobe low.
- R2: In fetch step 1 the address register takes the program counter. In fetch step 2 the read strobe is high and the memory address equals the program counter value from step 1.
- R3: At the end of fetch step 3 the instruction register holds the memory word read at that address.
- R4: The program counter rises by exactly one per fetched instruction, at the end of fetch step 2, and wraps from 2047 to 0. It does not change in any other step.
- R5: The instruction register does not change during fetch step 2 or fetch step 3. The buffer register load and the instruction register load fall in different steps.
- R6: After fetch step 3, the controller enters indirect step 1 if bit 11 of the fetched word is 1. Otherwise it goes straight to the execute step.
- R7: In indirect step 2 the read strobe is high and the memory address equals bits 10:0 of the instruction register. At the end of indirect step 3, bits 10:0 of the instruction register take bits 10:0 of the word read. Bit 11 is cleared and the opcode is kept, so the register matches a direct-addressed instruction.
- R8: The execute cycle lasts exactly one step, keeps the read strobe low, and is always followed by fetch step 1.
- R9: The cycle output encodes fetch as 0, indirect as 1 and execute as 2. The step output reads 1, 2 or 3, and reads 1 in the execute cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 11 | Memory read address, driven from the address register |
| mem_rd | output | 1 | Read strobe, high in the step that captures read data |
| mem_rdata | input | 16 | Read data, captured at the end of a strobe step |
| cyc_o | output | 2 | Current cycle: 0 fetch, 1 indirect, 2 execute |
| step_o | output | 2 | Current step within the cycle, 1 to 3 |
| ir_o | output | 16 | Instruction register |
| pc_o | output | 11 | Program counter |

## Verification
The bench builds the block with its default widths: 16-bit words and an 11-bit address. This gives a 2048-word memory that the bench can model in full and preload with random words, about a third of them flagged indirect. With that address width, the program counter wrap from 2047 to 0 is reached in a little over two thousand instructions. This brings the wrap, and an indirect word stored at the last address, within reach of a short run. A reset asserted partway through a fetch is also covered.

// File: rtl/uop_seq_pkg.sv
package uop_seq_pkg;

  typedef enum logic [1:0] {
    CYC_FETCH = 2'd0,
    CYC_INDIR = 2'd1,
    CYC_EXEC  = 2'd2
  } cyc_e;

  typedef enum logic [2:0] {
    ST_F1, ST_F2, ST_F3,
    ST_I1, ST_I2, ST_I3,
    ST_E1
  } state_e;

endpackage

// File: rtl/uop_seq_fsm.sv
module uop_seq_fsm
  import uop_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mbr_flag,
  output logic       ld_mar,
  output logic       mar_from_ir,
  output logic       ld_mbr,
  output logic       pc_inc,
  output logic       ld_ir,
  output logic       ld_ir_addr,
  output logic [1:0] cyc,
  output logic [1:0] step
);

  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_F1: state_d = ST_F2;
      ST_F2: state_d = ST_F3;
      ST_F3: state_d = mbr_flag ? ST_I1 : ST_E1;
      ST_I1: state_d = ST_I2;
      ST_I2: state_d = ST_I3;
      ST_I3: state_d = ST_E1;
      default: state_d = ST_F1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_F1;
    else     state_q <= state_d;
  end

  // Transfer strobes, one named wire per micro-operation
  assign ld_mar      = (state_q == ST_F1) || (state_q == ST_I1);
  assign mar_from_ir = (state_q == ST_I1);
  assign ld_mbr      = (state_q == ST_F2) || (state_q == ST_I2);
  assign pc_inc      = (state_q == ST_F2);
  assign ld_ir       = (state_q == ST_F3);
  assign ld_ir_addr  = (state_q == ST_I3);

  always_comb begin
    case (state_q)
      ST_F1: begin cyc = CYC_FETCH; step = 2'd1; end
      ST_F2: begin cyc = CYC_FETCH; step = 2'd2; end
      ST_F3: begin cyc = CYC_FETCH; step = 2'd3; end
      ST_I1: begin cyc = CYC_INDIR; step = 2'd1; end
      ST_I2: begin cyc = CYC_INDIR; step = 2'd2; end
      ST_I3: begin cyc = CYC_INDIR; step = 2'd3; end
      default: begin cyc = CYC_EXEC; step = 2'd1; end
    endcase
  end

endmodule

// File: rtl/uop_seq_datapath.sv
module uop_seq_datapath #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_mar,
  input  logic              mar_from_ir,
  input  logic              ld_mbr,
  input  logic              pc_inc,
  input  logic              ld_ir,
  input  logic              ld_ir_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mar,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ir,
  output logic              mbr_flag
);

  localparam int FLAG_BIT = ADDR_W;

  logic [DATA_W-1:0] mbr;

  function automatic logic [ADDR_W-1:0] pc_next(input logic [ADDR_W-1:0] p);
    return p + {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [DATA_W-1:0] ir_resolve(input logic [DATA_W-1:0] cur,
                                                   input logic [DATA_W-1:0] buf_w);
    logic [DATA_W-1:0] r;
    r = cur;
    r[FLAG_BIT]     = 1'b0;
    r[ADDR_W-1:0]   = buf_w[ADDR_W-1:0];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      mar <= '0;
      mbr <= '0;
      pc  <= '0;
      ir  <= '0;
    end else begin
      if (ld_mar) mar <= mar_from_ir ? ir[ADDR_W-1:0] : pc;
      if (ld_mbr) mbr <= mem_rdata;
      if (pc_inc) pc  <= pc_next(pc);
      if (ld_ir)  ir  <= mbr;
      else if (ld_ir_addr) ir <= ir_resolve(ir, mbr);
    end
  end

  assign mbr_flag = mbr[FLAG_BIT];

endmodule

// File: rtl/uop_sequencer.sv
module uop_sequencer #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [1:0]        cyc_o,
  output logic [1:0]        step_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [ADDR_W-1:0] pc_o
);

  logic ld_mar, mar_from_ir, ld_mbr, pc_inc, ld_ir, ld_ir_addr, mbr_flag;

  uop_seq_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .mbr_flag   (mbr_flag),
    .ld_mar     (ld_mar),
    .mar_from_ir(mar_from_ir),
    .ld_mbr     (ld_mbr),
    .pc_inc     (pc_inc),
    .ld_ir      (ld_ir),
    .ld_ir_addr (ld_ir_addr),
    .cyc        (cyc_o),
    .step       (step_o)
  );

  uop_seq_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .ld_mar     (ld_mar),
    .mar_from_ir(mar_from_ir),
    .ld_mbr     (ld_mbr),
    .pc_inc     (pc_inc),
    .ld_ir      (ld_ir),
    .ld_ir_addr (ld_ir_addr),
    .mem_rdata  (mem_rdata),
    .mar        (mem_addr),
    .pc         (pc_o),
    .ir         (ir_o),
    .mbr_flag   (mbr_flag)
  );

  assign mem_rd = ld_mbr;

endmodule

// File: rtl/uop_seq_checker.sv
module uop_seq_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_rd,
  input logic [1:0]        cyc_o,
  input logic [1:0]        step_o,
  input logic [DATA_W-1:0] ir_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic              ld_mar,
  input logic              ld_mbr,
  input logic              ld_ir
);

  a_r9_legal_code: assert property (@(posedge clk) disable iff (rst)
    (cyc_o != 2'd3) && (step_o != 2'd0) && ((cyc_o != 2'd2) || (step_o == 2'd1)));

  a_r2_read_in_step2: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (step_o == 2'd2) && (cyc_o != 2'd2));

  a_r2_mar_before_read: assert property (@(posedge clk) disable iff (rst)
    ld_mbr |-> $past(ld_mar));

  a_r5_split_steps: assert property (@(posedge clk) disable iff (rst)
    !(ld_mbr && ld_ir));

  a_r4_pc_step: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && cyc_o == 2'd0) |=> (pc_o == $past(pc_o) + 1'b1));

  a_r4_pc_hold: assert property (@(posedge clk) disable iff (rst)
    (cyc_o != 2'd0 || step_o != 2'd2) |=> $stable(pc_o));

  a_r7_flag_cleared: assert property (@(posedge clk) disable iff (rst)
    (cyc_o == 2'd1 && step_o == 2'd3) |=> (!ir_o[ADDR_W] && cyc_o == 2'd2));

  a_r8_exec_returns: assert property (@(posedge clk) disable iff (rst)
    (cyc_o == 2'd2) |=> (cyc_o == 2'd0 && step_o == 2'd1));

endmodule

bind uop_sequencer uop_seq_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .mem_rd(mem_rd),
  .cyc_o (cyc_o),
  .step_o(step_o),
  .ir_o  (ir_o),
  .pc_o  (pc_o),
  .ld_mar(ld_mar),
  .ld_mbr(ld_mbr),
  .ld_ir (ld_ir)
);

// File: tb/tb_uop_sequencer.sv
module tb_uop_sequencer;
  localparam int DW = 16;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic          mem_rd;
  logic [DW-1:0] mem_rdata;
  logic [1:0]    cyc_o, step_o;
  logic [DW-1:0] ir_o;
  logic [AW-1:0] pc_o;

  logic [DW-1:0] mem [DEPTH];
  assign mem_rdata = mem[mem_addr];

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [AW-1:0] m_pc;
  logic [DW-1:0] m_ir;

  always #10 clk = ~clk;

  uop_sequencer dut (.*);

  function automatic logic [DW-1:0] resolved(input logic [DW-1:0] w, input logic [DW-1:0] tgt);
    return {w[15:12], 1'b0, tgt[10:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input int c, input int s);
    chk(cyc_o == 2'(c) && step_o == 2'(s), req, {cyc_o, step_o}, (c << 2) | s);
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic one_instr;
    logic [DW-1:0] w;
    chk_state("R9 fetch1", 0, 1);
    chk(pc_o == m_pc, "R4 pc at fetch1", pc_o, m_pc);
    chk(!mem_rd, "R2 no read in fetch1", mem_rd, 0);
    tick;
    chk_state("R9 fetch2", 0, 2);
    chk(mem_rd && mem_addr == m_pc, "R2 read addr", {mem_rd, mem_addr}, {1'b1, m_pc});
    chk(ir_o == m_ir, "R5 ir held in fetch2", ir_o, m_ir);
    tick;
    chk_state("R9 fetch3", 0, 3);
    chk(pc_o == AW'(m_pc + 1), "R4 pc increment", pc_o, AW'(m_pc + 1));
    chk(ir_o == m_ir, "R5 ir held in fetch3", ir_o, m_ir);
    w = mem[m_pc];
    m_pc = AW'(m_pc + 1);
    m_ir = w;
    tick;
    chk(ir_o == m_ir, "R3 ir loaded", ir_o, m_ir);
    if (w[11]) begin
      chk_state("R6 indirect entry", 1, 1);
      tick;
      chk_state("R9 indirect2", 1, 2);
      chk(mem_rd && mem_addr == m_ir[10:0], "R7 indirect read addr",
          {mem_rd, mem_addr}, {1'b1, m_ir[10:0]});
      tick;
      chk_state("R9 indirect3", 1, 3);
      m_ir = resolved(m_ir, mem[m_ir[10:0]]);
      tick;
      chk(ir_o == m_ir, "R7 ir resolved", ir_o, m_ir);
    end
    chk_state("R6 R8 execute", 2, 1);
    chk(!mem_rd && pc_o == m_pc, "R8 exec quiet", {mem_rd, pc_o}, {1'b0, m_pc});
    tick;
  endtask

  task automatic check_reset;
    chk_state("R1 reset state", 0, 1);
    chk(pc_o == 0 && ir_o == 0 && !mem_rd, "R1 regs zero", {pc_o, ir_o, mem_rd}, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < DEPTH; i++) begin
      logic [DW-1:0] r;
      r = DW'($urandom);
      r[11] = ($urandom % 3) == 0;
      mem[i] = r;
    end
    mem[0]       = {4'h3, 1'b1, 11'd5};
    mem[5]       = 16'hFFFF;
    mem[1]       = {4'hA, 1'b0, 11'h123};
    mem[2]       = {4'h7, 1'b1, 11'd2047};
    mem[DEPTH-1] = {4'hC, 1'b1, 11'd0};

    rst = 1'b1;
    repeat (2) @(posedge clk);
    tick;
    rst = 1'b0;
    check_reset;
    m_pc = '0;
    m_ir = '0;

    // mid-fetch reset: enter fetch step 2 then reset
    tick;
    rst = 1'b1;
    tick;
    rst = 1'b0;
    check_reset;

    // directed: indirect at 0, direct at 1, indirect to last address at 2
    for (int k = 0; k < 3; k++) one_instr;
    chk(m_ir == 16'h7000 | mem[DEPTH-1][10:0], "R7 directed", m_ir, 16'h7000 | mem[DEPTH-1][10:0]);

    // random run through the program counter wrap
    for (int k = 0; k < DEPTH + 40; k++) one_instr;
    chk(m_pc == AW'(DEPTH + 43), "R4 wrap reached", m_pc, AW'(DEPTH + 43));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule